// File: doc/BRIEF.md
# Unaligned partial store lane generator

This block breaks an unaligned "store left" or "store right" request into single-byte writes. A request carries a register value, a byte address, a left/right select, a word/doubleword size select and a big-endian configuration bit. The block writes only the part of the register that belongs in the memory word containing the address. It issues that part as one byte per accepted cycle on a simple valid/ready byte port. When the last byte has been accepted, it pulses `done`.

The block takes the low address bits, masked to the access size, as an offset index. In little-endian mode it inverts that index within the size. This index sets how many bytes go out. The big-endian bit also sets which way the byte address walks. The left and right operations mirror each other. Left starts from the most significant register byte and walks away from the given address. Right starts from the least significant byte and walks the other way. The block accepts a new request only while it is idle.

Top module: `partial_store_sequencer`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `wr_valid`=0, `done`=0.
- R2: The index is `addr & m`, where m = 3 for word (`req_dword`=0) and m = 7 for doubleword (`req_dword`=1). When `req_big_endian`=0 the index is XORed with m. A left store (`req_right`=0) writes m+1-index bytes. A right store (`req_right`=1) writes index+1 bytes.
- R3: Left store, k-th byte issued (k from 0): the data is register byte m-k, where byte j is bits [8j+7:8j].
- R4: Right store, k-th byte issued: the data is register byte k.
- R5: Let d be +1 when `req_big_endian`=1 and -1 when it is 0. The k-th address is addr+k·d for a left store and addr-k·d for a right store.
- R6: A word left store with index 0 writes four bytes. A word right store writes four bytes only when the index is 3.
- R7: Bytes are issued in increasing k, and the first one is at the request address.
- R8: While `wr_valid`=1 and `wr_ready`=0, `wr_valid`, `wr_addr` and `wr_byte` hold their values.
- R9: `done` is high for exactly one cycle, in the cycle after the last byte is accepted. `req_ready` returns to 1 in the following cycle.
- R10: A request presented while `req_ready`=0 is ignored, and the byte sequence in progress is unchanged.
- R11: In word mode, register bits 63:32 never appear on `wr_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block idle, request accepted |
| req_right | input | 1 | 0 = left store, 1 = right store |
| req_dword | input | 1 | 0 = 32-bit, 1 = 64-bit |
| req_big_endian | input | 1 | Endianness configuration bit |
| req_addr | input | ADDR_W | Byte address |
| req_data | input | REG_W | Register value |
| wr_valid | output | 1 | Byte write valid |
| wr_ready | input | 1 | Byte write accepted |
| wr_addr | output | ADDR_W | Byte write address |
| wr_byte | output | 8 | Byte write data |
| done | output | 1 | Pulse after last byte |

## Verification
The assertions check the following on every cycle:
- the port holds steady under back-pressure;
- consecutive byte addresses differ by exactly one;
- no request produces more bytes than the register holds;
- `done` lasts one cycle, comes only after at least one byte, and returns the block to idle;
- the block never offers a byte while it is ready for a request.

Only the bench scenarios can show the exact byte count for each index and endianness, the choice of register byte, the direction of the address walk, and that a request arriving mid-sequence leaves the sequence unchanged.

// File: rtl/partial_store_sequencer.sv
module partial_store_sequencer #(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_right,
  input  logic              req_dword,
  input  logic              req_big_endian,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_W-1:0]  req_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_byte,
  output logic              done
);
  localparam int BYTES = REG_W / 8;
  localparam int IDX_W = $clog2(BYTES);
  localparam int CNT_W = IDX_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_DONE} state_t;

  state_t             state;
  logic [IDX_W-1:0]   mask, idx, top_q, sel;
  logic [CNT_W-1:0]   nbytes, k, last_k;
  logic [REG_W-1:0]   data_q;
  logic               right_q, up_q;

  assign mask   = req_dword ? IDX_W'(BYTES - 1) : IDX_W'(BYTES / 2 - 1);
  assign idx    = (req_addr[IDX_W-1:0] & mask) ^ (req_big_endian ? '0 : mask);
  assign nbytes = req_right ? CNT_W'(idx) + CNT_W'(1)
                            : CNT_W'(mask) + CNT_W'(1) - CNT_W'(idx);

  assign req_ready = (state == S_IDLE);
  assign wr_valid  = (state == S_SEND);
  assign done      = (state == S_DONE);
  assign sel       = right_q ? k[IDX_W-1:0] : top_q - k[IDX_W-1:0];
  assign wr_byte   = data_q[8*sel +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      wr_addr <= '0;
      k       <= '0;
      last_k  <= '0;
      data_q  <= '0;
      top_q   <= '0;
      right_q <= 1'b0;
      up_q    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          state   <= S_SEND;
          wr_addr <= req_addr;
          k       <= '0;
          last_k  <= nbytes - CNT_W'(1);
          data_q  <= req_data;
          top_q   <= mask;
          right_q <= req_right;
          up_q    <= req_right ^ req_big_endian;
        end
        S_SEND: if (wr_ready) begin
          wr_addr <= up_q ? wr_addr + ADDR_W'(1) : wr_addr - ADDR_W'(1);
          k       <= k + CNT_W'(1);
          if (k == last_k) state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module partial_store_sequencer_chk #(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_byte,
  input logic              done
);
  logic [7:0] seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (done) seen <= '0;
    else if (wr_valid && wr_ready) seen <= seen + 8'd1;
  end

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_byte)));
  assert_unit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (!wr_valid || wr_addr == $past(wr_addr) + ADDR_W'(1)
                                || wr_addr == $past(wr_addr) - ADDR_W'(1)));
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seen <= 8'(REG_W / 8));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (req_ready && !done));
  assert_done_after_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (seen != 8'd0 && !wr_valid));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!wr_valid && !done));
endmodule

bind partial_store_sequencer partial_store_sequencer_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_byte(wr_byte), .done(done));

// File: tb/tb_partial_store_sequencer.sv
module tb_partial_store_sequencer;
  localparam int ADDR_W = 32;
  localparam int REG_W  = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_right = 1'b0, req_dword = 1'b0, req_big_endian = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [REG_W-1:0]  req_data = '0;
  logic wr_ready = 1'b0;
  logic req_ready, wr_valid, done;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0] wr_byte;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  partial_store_sequencer #(.ADDR_W(ADDR_W), .REG_W(REG_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_right(req_right), .req_dword(req_dword), .req_big_endian(req_big_endian),
    .req_addr(req_addr), .req_data(req_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_byte(wr_byte), .done(done));

  // {right, dword, big_endian, addr_low[7:0], expected byte count}
  localparam logic [14:0] VEC [16] = '{
    {1'b0, 1'b0, 1'b1, 8'h10, 4'd4}, {1'b0, 1'b0, 1'b1, 8'h13, 4'd1},
    {1'b1, 1'b0, 1'b1, 8'h13, 4'd4}, {1'b1, 1'b0, 1'b1, 8'h11, 4'd2},
    {1'b0, 1'b0, 1'b0, 8'h10, 4'd1}, {1'b0, 1'b0, 1'b0, 8'h13, 4'd4},
    {1'b1, 1'b0, 1'b0, 8'h13, 4'd1}, {1'b1, 1'b0, 1'b0, 8'h12, 4'd2},
    {1'b0, 1'b1, 1'b1, 8'h20, 4'd8}, {1'b0, 1'b1, 1'b1, 8'h25, 4'd3},
    {1'b1, 1'b1, 1'b1, 8'h27, 4'd8}, {1'b1, 1'b1, 1'b1, 8'h22, 4'd3},
    {1'b0, 1'b1, 1'b0, 8'h23, 4'd4}, {1'b1, 1'b1, 1'b0, 8'h26, 4'd2},
    {1'b1, 1'b1, 1'b0, 8'h20, 4'd8}, {1'b0, 1'b1, 1'b0, 8'h2F, 4'd8}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input bit right, input bit dword, input bit be,
                     input logic [ADDR_W-1:0] addr, input logic [REG_W-1:0] data,
                     input int expn, input bit poke, input int stall_mod);
    int top = dword ? 7 : 3;
    int dir = be ? 1 : -1;
    int got = 0;
    bit saw_done = 0;
    bit stalled = 0;
    logic [ADDR_W-1:0] held_addr = '0;
    logic [7:0] held_byte = '0;
    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready before request", req_ready, 1);
    req_valid = 1'b1; req_right = right; req_dword = dword;
    req_big_endian = be; req_addr = addr; req_data = data;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 80; c++) begin
      if (done) begin
        saw_done = 1;
        check(got == expn, "R9 done right after last byte", got, expn);
        break;
      end
      if (poke && c == 0) begin
        req_valid = 1'b1; req_right = ~right; req_dword = ~dword;
        req_big_endian = ~be; req_addr = addr ^ 32'h55; req_data = ~data;
        check(req_ready == 1'b0, "R10 busy ignores request", req_ready, 0);
      end else begin
        req_valid = 1'b0;
      end
      if (stalled) begin
        check(wr_valid && wr_addr == held_addr && wr_byte == held_byte,
              "R8 hold under stall", {wr_addr, wr_byte}, {held_addr, held_byte});
      end
      wr_ready = (c % stall_mod) != (stall_mod - 1);
      stalled = wr_valid && !wr_ready;
      held_addr = wr_addr; held_byte = wr_byte;
      if (wr_valid && wr_ready) begin
        logic [ADDR_W-1:0] ea;
        logic [7:0] eb;
        ea = right ? addr - ADDR_W'(got * dir) : addr + ADDR_W'(got * dir);
        eb = right ? data[8*got +: 8] : data[8*(top - got) +: 8];
        check(wr_addr == ea, "R5 R7 byte address", wr_addr, ea);
        // word mode: bytes come from bits 31:0 only (R11)
        check(wr_byte == eb, dword ? (right ? "R4 right byte" : "R3 left byte")
                                   : "R11 word byte select", wr_byte, eb);
        got++;
      end
      @(posedge clk); @(negedge clk);
    end
    wr_ready = 1'b0; req_valid = 1'b0;
    check(saw_done, "R9 done seen", saw_done, 1);
    check(got == expn, dword ? "R2 byte count" : "R6 R2 word byte count", got, expn);
    @(negedge clk);
    check(req_ready == 1'b1 && done == 1'b0, "R9 idle after done", {req_ready, done}, 2'b10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b1 && wr_valid == 1'b0 && done == 1'b0, "R1 reset state",
          {req_ready, wr_valid, done}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && wr_valid == 1'b0, "R1 idle after reset", {req_ready, wr_valid}, 2'b10);

    for (int i = 0; i < 16; i++) begin
      logic [14:0] v = VEC[i];
      run(v[14], v[13], v[12], 32'h0000_1000 | ADDR_W'(v[11:4]),
          64'h8877_6655_4433_2211 + 64'(i) * 64'h0101_0101_0101_0101,
          int'(v[3:0]), 1'b0, (i % 3) + 2);
    end

    // R6 boundary cases: left word index 0 and right word index 3, no stalls
    run(1'b0, 1'b0, 1'b1, 32'h0000_2004, 64'hFFEE_DDCC_A1B2_C3D4, 4, 1'b0, 1000);
    run(1'b1, 1'b0, 1'b0, 32'h0000_2004, 64'hFFEE_DDCC_A1B2_C3D4, 4, 1'b0, 1000);
    run(1'b1, 1'b0, 1'b1, 32'h0000_2006, 64'hFFEE_DDCC_A1B2_C3D4, 3, 1'b0, 1000);
    // R10: request poked during a busy doubleword sequence
    run(1'b0, 1'b1, 1'b1, 32'h0000_3000, 64'h0123_4567_89AB_CDEF, 8, 1'b1, 2);
    run(1'b1, 1'b1, 1'b0, 32'h0000_3001, 64'h0123_4567_89AB_CDEF, 7, 1'b1, 4);
    // R8: long stall pattern
    run(1'b1, 1'b1, 1'b1, 32'h0000_4007, 64'hCAFE_F00D_DEAD_BEEF, 8, 1'b0, 2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule